// File: doc/BRIEF.md
# Activity-Adaptive Scan Shift Clock

This block paces the scan-in of a scan-BIST engine that loads several parallel scan chains at once. It issues a one-master-cycle shift pulse per scan-clock period. Each scan-in starts at the slowest period, eight master cycles. The block watches the serial bit offered to every chain and keeps, per chain, a running count of shifts in which the new bit repeated the previous one. A repeated bit means no toggle propagates down the chain. The quieter the load has been on every chain, the shorter the shift period becomes. Peak shift power therefore stays within the budget that the slowest clock sets.

The sequencer has three states. `ST_IDLE` holds after reset. `ST_SHIFT` paces the load. `ST_CAPTURE` holds the lowest frequency and raises `shift_done`. The transitions are named as follows:
- start: any state goes to `ST_SHIFT` when `vec_start` is high.
- load_complete: `ST_SHIFT` goes to `ST_CAPTURE` on the pulse that completes `CHAIN_LEN` shifts.
- wait: every other case stays in the current state.

The four levels are level 0 (master/8), level 1 (master/4), level 2 (master/2) and level 3 (master/1).

Top module: `adaptive_scan_clk`

## Requirements
- R1: After reset, `freq_level` is 0, and `shift_clk` and `shift_done` are low.
- R2: Every scan-in begins at level 0. `vec_start` clears all counts, the pulse count and the level. The first pulse after it comes 8 cycles later.
- R3: A chain's count grows by one on a shift pulse whose bit equals that chain's bit at the previous pulse of the same scan-in. The first pulse of a scan-in never counts.
- R4: The level changes only on a cycle in which a shift pulse or `vec_start` occurs.
- R5: The level rises by at most one step at a time.
- R6: After each pulse the level is floor(minimum count / STEP_THRESH), saturated at 3.
- R7: The minimum across all chains decides the level. A single active chain holds every chain at the lower level.
- R8: The gap from one pulse (or from the start) to the next pulse is 8 >> level cycles, using the level in force during that gap. A period is never shortened.
- R9: The level saturates at 3. At that level, pulses come every master cycle.
- R10: `shift_done` rises after exactly `CHAIN_LEN` pulses. In that state `freq_level` reads 0 and no pulse is issued.
- R11: While `scan_en` is low, no pulse is issued and the period phase holds.
- R12: `vec_start` takes priority over a pulse due in the same cycle. No pulse is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Allows shifting; low pauses the load |
| vec_start | input | 1 | Start strobe for a new scan-in |
| chain_bits | input | NUM_CHAINS | Bit being offered to each chain; chain c on bit c |
| shift_clk | output | 1 | Shift pulse; the chains shift on the clock edge that ends a high cycle |
| freq_level | output | 2 | Current frequency level, 0 = master/8 to 3 = master |
| shift_done | output | 1 | High once the full chain length has been shifted |

## Verification
Two events can coincide in one cycle: a start strobe and a shift pulse that the divider is about to issue. The bench provokes this by waiting, partway through a quiet load running at level 2, until `shift_clk` is seen high. It then raises `vec_start` in that same cycle. The pulse must vanish at once. The level must read 0 on the next cycle, and the following load must show a full 8-cycle first gap and exactly `CHAIN_LEN` pulses.

// File: rtl/asc_pkg.sv
package asc_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = 2;
    localparam int DIV_MAX = 1 << (NUM_LVL - 1);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_CAPTURE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/asc_divider.sv
module asc_divider
    import asc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [LVL_W-1:0] level,
    output logic             fire
);
    localparam int TICK_W = $clog2(DIV_MAX);

    logic [TICK_W-1:0] tick_q;
    logic [TICK_W:0]   period;

    always_comb begin
        period = (TICK_W+1)'(DIV_MAX) >> level;
        fire   = run && ({1'b0, tick_q} == period - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick_q <= '0;
        else if (restart) tick_q <= '0;
        else if (fire)    tick_q <= '0;
        else if (run)     tick_q <= tick_q + 1'b1;
    end

    // R11: phase holds while not running
    p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(tick_q));
endmodule

// File: rtl/asc_monitor.sv
module asc_monitor #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic             bit_in,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic             prev_q;
    logic             have_prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_nxt = cnt_q;
        if (fire && have_prev_q && (bit_in == prev_q))
            cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (clear) begin
            cnt_q       <= '0;
            have_prev_q <= 1'b0;
        end else if (fire) begin
            cnt_q       <= cnt_nxt;
            prev_q      <= bit_in;
            have_prev_q <= 1'b1;
        end
    end

    // R3: count only moves on a shift pulse
    p_count_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/asc_level.sv
module asc_level
    import asc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 5,
    parameter int THRESH = 4
) (
    input  logic [NCH*CNT_W-1:0] counts,
    output logic [LVL_W-1:0]     target
);
    logic [CNT_W-1:0] mn;
    logic [CNT_W-1:0] quo;

    always_comb begin
        mn = counts[CNT_W-1:0];
        for (int c = 1; c < NCH; c++) begin
            if (counts[c*CNT_W +: CNT_W] < mn)
                mn = counts[c*CNT_W +: CNT_W];
        end
        quo = mn / CNT_W'(THRESH);
        if (quo > CNT_W'(NUM_LVL - 1)) target = LVL_W'(NUM_LVL - 1);
        else                           target = quo[LVL_W-1:0];
    end
endmodule

// File: rtl/adaptive_scan_clk.sv
module adaptive_scan_clk
    import asc_pkg::*;
#(
    parameter int NUM_CHAINS  = 4,
    parameter int CHAIN_LEN   = 16,
    parameter int STEP_THRESH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_en,
    input  logic                  vec_start,
    input  logic [NUM_CHAINS-1:0] chain_bits,
    output logic                  shift_clk,
    output logic [1:0]            freq_level,
    output logic                  shift_done
);
    localparam int CNT_W = $clog2(CHAIN_LEN + 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0]            pcnt_q;
    logic [LVL_W-1:0]            level_q;
    logic [LVL_W-1:0]            target;
    logic [NUM_CHAINS*CNT_W-1:0] counts;
    logic                        run;
    logic                        fire;
    logic                        last_pulse;

    // next-state logic
    always_comb begin
        state_d    = state_q;
        last_pulse = fire && (pcnt_q == CNT_W'(CHAIN_LEN - 1));
        if (vec_start) state_d = ST_SHIFT;
        else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SHIFT:   if (last_pulse) state_d = ST_CAPTURE;
                ST_CAPTURE: state_d = ST_CAPTURE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            if (vec_start) begin
                pcnt_q  <= '0;
                level_q <= '0;
            end else if (fire) begin
                pcnt_q  <= pcnt_q + 1'b1;
                level_q <= target;
            end
        end
    end

    // outputs
    always_comb begin
        run        = (state_q == ST_SHIFT) && scan_en && !vec_start;
        shift_clk  = fire;
        shift_done = (state_q == ST_CAPTURE);
        freq_level = (state_q == ST_SHIFT) ? level_q : 2'd0;
    end

    asc_divider u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (vec_start),
        .level   (level_q),
        .fire    (fire)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_mon
        asc_monitor #(.CNT_W(CNT_W)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (vec_start),
            .fire    (fire),
            .bit_in  (chain_bits[c]),
            .cnt_nxt (counts[c*CNT_W +: CNT_W])
        );
    end

    asc_level #(.NCH(NUM_CHAINS), .CNT_W(CNT_W), .THRESH(STEP_THRESH)) u_lvl (
        .counts (counts),
        .target (target)
    );

    p_start_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_start |=> (freq_level == 2'd0));
    p_level_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !vec_start) |=> $stable(level_q));
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q > $past(level_q)) |-> (level_q == $past(level_q) + 1'b1));
    p_no_short_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || level_q == 2'd3));
    p_capture_slow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |-> (freq_level == 2'd0 && !shift_clk));
    p_pause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !shift_clk);
    p_start_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vec_start |-> !shift_clk);
endmodule

// File: tb/adaptive_scan_clk_tb.sv
module adaptive_scan_clk_tb_top;
    localparam int NCH = 4;
    localparam int LEN = 16;
    localparam int TH  = 4;
    localparam int NCASE = 6;

    // chain c pattern at bits [c*16 +: 16]; bit k is offered at pulse k
    localparam logic [63:0] PAT [NCASE] = '{
        64'h5555_5555_5555_5555,
        64'h0000_0000_0000_0000,
        64'h0000_0000_0000_5555,
        64'hAA00_AA00_AA00_AA00,
        64'hFFFF_0000_FFFF_0000,
        64'hAA00_0000_0000_0000
    };
    localparam int PEAK [NCASE] = '{0, 3, 0, 2, 3, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic vec_start = 1'b0;
    logic [NCH-1:0] chain_bits = '0;
    logic shift_clk;
    logic [1:0] freq_level;
    logic shift_done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    adaptive_scan_clk #(.NUM_CHAINS(NCH), .CHAIN_LEN(LEN), .STEP_THRESH(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .vec_start(vec_start),
        .chain_bits(chain_bits), .shift_clk(shift_clk),
        .freq_level(freq_level), .shift_done(shift_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // walks one scan-in; returns early (pulse pending, not consumed) at pulse index stop_at
    task automatic run_scan(input logic [63:0] pat, input bit do_start, input int stop_at,
                            output int peak, output int pulses, output int errs);
        int cnt [NCH];
        int lvl, gap, mn;
        peak = 0; pulses = 0; errs = 0; lvl = 0; gap = 0;
        foreach (cnt[c]) cnt[c] = 0;
        if (do_start) begin
            @(negedge clk); vec_start = 1'b1;
            @(negedge clk); vec_start = 1'b0;
        end
        for (int it = 0; it < 400; it++) begin
            for (int c = 0; c < NCH; c++) chain_bits[c] = pat[c*LEN + (pulses % LEN)];
            #1;
            gap++;
            if (shift_done) return;
            if (freq_level != 2'(lvl)) errs++;
            if (shift_clk) begin
                if (pulses == stop_at) return;
                if (gap != (8 >> lvl)) errs++;
                for (int c = 0; c < NCH; c++)
                    if (pulses > 0 && pat[c*LEN + pulses] == pat[c*LEN + pulses - 1]) cnt[c]++;
                mn = cnt[0];
                for (int c = 1; c < NCH; c++) if (cnt[c] < mn) mn = cnt[c];
                lvl = (mn / TH > 3) ? 3 : mn / TH;
                if (lvl > peak) peak = lvl;
                pulses++;
                gap = 0;
            end
            @(negedge clk);
        end
        errs++;
    endtask

    initial begin
        int pk, np, er;
        #20000;
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pk, np, er;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(freq_level == 2'd0 && !shift_clk && !shift_done, "R1", {shift_clk, shift_done, freq_level}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_level == 2'd0 && !shift_clk && !shift_done, "R1", {shift_clk, shift_done, freq_level}, 0);
        scan_en = 1'b1;

        // table walk: R3 R6 R7 R8 R9 R10
        for (int i = 0; i < NCASE; i++) begin
            run_scan(PAT[i], 1'b1, -1, pk, np, er);
            check(er == 0, "R8 gap/level (R3,R6)", er, 0);
            check(pk == PEAK[i], "R6/R7/R9 peak level", pk, PEAK[i]);
            check(np == LEN && shift_done, "R10 pulse count", np, LEN);
            check(freq_level == 2'd0 && !shift_clk, "R10 capture level", freq_level, 0);
        end

        // R11: scan_en low pauses, then resumes with full first gap
        scan_en = 1'b0;
        @(negedge clk); vec_start = 1'b1;
        @(negedge clk); vec_start = 1'b0;
        er = 0;
        for (int k = 0; k < 20; k++) begin
            #1; if (shift_clk || shift_done) er++;
            @(negedge clk);
        end
        check(er == 0, "R11 paused", er, 0);
        scan_en = 1'b1;
        run_scan(64'h0, 1'b0, -1, pk, np, er);
        check(er == 0 && np == LEN, "R11 resume", er, 0);

        // R12/R2 collision: start strobe in a pulse cycle at level 2
        run_scan(64'h0, 1'b1, 12, pk, np, er);
        check(freq_level == 2'd2 && shift_clk, "R12 setup", freq_level, 2);
        vec_start = 1'b1;
        #1;
        check(!shift_clk, "R12 pulse suppressed", shift_clk, 0);
        @(negedge clk); vec_start = 1'b0;
        #1;
        check(freq_level == 2'd0, "R2 level cleared", freq_level, 0);
        @(negedge clk);
        run_scan(64'h0, 1'b0, -1, pk, np, er);
        check(er <= 1 && np == LEN && pk == 3, "R2 restart from lowest", np, LEN);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule